// File: doc/BRIEF.md
# Conversion and Power-Mode Sequencer

This block is the digital control sequencer of a successive-approximation converter. It starts in a powered-down state and leaves it only after a configuration write asks for power. Once configured, it uses a single convert-start input to wake the converter, to start conversions and to choose the power mode. The analog front end and the bit-by-bit approximation are not modelled. The result word comes from an input port, and the block decides when that word is handed to the serial output register.

Convert-start passes through a two-flop synchronizer, and edge detection works on the synchronized level. A falling edge while powered and idle starts a conversion that lasts a fixed number of clock cycles. When the conversion ends, the synchronized convert-start level is examined. If it is high, the converter stays powered for fast back-to-back sampling. If it is low, the converter powers down until a rising edge wakes it again. Wake-up takes a fixed number of cycles. If convert-start falls before wake-up is complete, the fall is remembered and the conversion starts on its own once the converter is ready. If a serial read is in progress when a conversion ends, the load of the result into the shift register is held back until the read is over.

Top module: `adcseq_top`

## Requirements
- R1: After reset, pwr_state is 0 (off), busy is 0 and load_strobe is 0. Convert-start edges have no effect until a cycle with cfg_we=1 and cfg_pwr_on=1. That write moves pwr_state to 1 (warming) on the next clock edge.
- R2: A falling edge of convert-start while pwr_state is 2 (on) and busy is 0 starts a conversion. busy is then high for exactly CONV_CYC clock cycles.
- R3: When a conversion ends and rd_active is low, load_strobe is high for exactly one cycle, starting on the same clock edge at which busy falls. load_data then equals the sample_in value from the last busy cycle. load_data changes only when load_strobe is asserted.
- R4: At the end of a conversion, the block samples the synchronized convert-start level. If it is high, pwr_state becomes 2 (on). If it is low, pwr_state becomes 0 (off).
- R5: pwr_state encodes 0 = off, 1 = warming, 2 = on. A configured block in the off state moves to warming on a rising edge of convert-start. Warming lasts exactly PWRUP_CYC cycles, and off is never left for any state other than warming.
- R6: If convert-start falls while the block is warming, the conversion starts on the edge at which warming ends, with no further edge needed.
- R7: If convert-start is still high when warming ends, pwr_state becomes 2 with busy low. The conversion starts on the later falling edge.
- R8: While rd_active is high, load_strobe stays low. A result that completes during a read is held. It is loaded, with load_strobe, on the first clock edge at which rd_active is low.
- R9: Convert-start edges that arrive while busy is high are ignored. They neither change the conversion length nor start another conversion.
- R10: A change on cnv_start driven between clock edges first changes the sequencer state at the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pwr_on | input | 1 | Power-up command carried with the configuration write |
| cnv_start | input | 1 | Asynchronous convert-start level |
| rd_active | input | 1 | High while a serial read of the output register is in progress |
| sample_in | input | DATA_W | Result word supplied by the converter model |
| busy | output | 1 | High while a conversion is running |
| pwr_state | output | 2 | 0 off, 1 warming, 2 on |
| load_strobe | output | 1 | One-cycle load of load_data into the output shift register |
| load_data | output | DATA_W | Result word being loaded |

## Verification
The bench builds the sequencer with PWRUP_CYC=6 and CONV_CYC=9 instead of the full-rate defaults of 75 and 115. With these values, a pulse width either shorter or longer than the warm-up window can be produced within a few cycles. The short window also lets the bench land convert-start changes inside a conversion, both before and after the synchronizer delay, with many conversions in each run. Both warm-up branches can be reached: a fall that arrives early and is remembered, and a fall that arrives after the block is ready. The exact boundary, where the pulse width equals PWRUP_CYC, is covered by a directed case.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [1:0] {
        PWR_OFF  = 2'd0,
        PWR_WARM = 2'd1,
        PWR_ON   = 2'd2
    } pwr_e;

    typedef enum logic [1:0] {
        SQ_OFF,
        SQ_WARM,
        SQ_READY,
        SQ_CONV
    } seq_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } cnv_evt_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to hold values 0 .. n-1
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic pwr_e pwr_of(input seq_e s);
        case (s)
            SQ_OFF:  return PWR_OFF;
            SQ_WARM: return PWR_WARM;
            default: return PWR_ON;
        endcase
    endfunction

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync
    import adcseq_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     async_in,
    output cnv_evt_t evt
);

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            prev <= chain[STAGES-1];
        end
    end

    always_comb begin
        evt.level = chain[STAGES-1];
        evt.rise  = chain[STAGES-1] & ~prev;
        evt.fall  = ~chain[STAGES-1] & prev;
    end

endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int unsigned PWRUP_CYC = 75,
    parameter int unsigned CONV_CYC  = 115,
    parameter int unsigned CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  cnv_evt_t         evt,
    input  logic             cfg_we,
    input  logic             cfg_pwr_on,
    input  logic             t_zero,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output seq_e             state,
    output logic             done
);

    localparam logic [CNT_W-1:0] PWRUP_LOAD = CNT_W'(PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_LOAD  = CNT_W'(CONV_CYC - 1);

    seq_e nxt;
    logic pend, pend_nxt;
    logic cfg_ok, cfg_nxt;
    logic wake_cmd;

    assign wake_cmd = cfg_we & cfg_pwr_on;

    always_comb begin
        nxt      = state;
        t_load   = 1'b0;
        t_val    = CONV_LOAD;
        pend_nxt = pend;
        cfg_nxt  = cfg_ok | wake_cmd;
        done     = 1'b0;
        case (state)
            SQ_OFF: begin
                if (wake_cmd || (cfg_ok && evt.rise)) begin
                    nxt      = SQ_WARM;
                    t_load   = 1'b1;
                    t_val    = PWRUP_LOAD;
                    pend_nxt = 1'b0;
                end
            end
            SQ_WARM: begin
                if (evt.fall) begin
                    pend_nxt = 1'b1;
                end
                if (t_zero) begin
                    pend_nxt = 1'b0;
                    if (pend || evt.fall) begin
                        nxt    = SQ_CONV;
                        t_load = 1'b1;
                    end else begin
                        nxt = SQ_READY;
                    end
                end
            end
            SQ_READY: begin
                if (evt.fall) begin
                    nxt    = SQ_CONV;
                    t_load = 1'b1;
                end
            end
            SQ_CONV: begin
                if (t_zero) begin
                    done = 1'b1;
                    nxt  = evt.level ? SQ_READY : SQ_OFF;
                end
            end
            default: nxt = SQ_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_OFF;
            pend   <= 1'b0;
            cfg_ok <= 1'b0;
        end else begin
            state  <= nxt;
            pend   <= pend_nxt;
            cfg_ok <= cfg_nxt;
        end
    end

endmodule

// File: rtl/adcseq_loader.sv
module adcseq_loader #(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic              rd_active,
    input  logic [DATA_W-1:0] sample_in,
    output logic              load_strobe,
    output logic [DATA_W-1:0] load_data
);

    logic              pend;
    logic [DATA_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend        <= 1'b0;
            held        <= '0;
            load_strobe <= 1'b0;
            load_data   <= '0;
        end else begin
            load_strobe <= 1'b0;
            if (done) begin
                if (!rd_active) begin
                    load_strobe <= 1'b1;
                    load_data   <= sample_in;
                    pend        <= 1'b0;
                end else begin
                    held <= sample_in;
                    pend <= 1'b1;
                end
            end else if (pend && !rd_active) begin
                load_strobe <= 1'b1;
                load_data   <= held;
                pend        <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int unsigned PWRUP_CYC   = 75,
    parameter int unsigned CONV_CYC    = 115,
    parameter int unsigned DATA_W      = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_pwr_on,
    input  logic              cnv_start,
    input  logic              rd_active,
    input  logic [DATA_W-1:0] sample_in,
    output logic              busy,
    output logic [1:0]        pwr_state,
    output logic              load_strobe,
    output logic [DATA_W-1:0] load_data
);

    localparam int unsigned CNT_W = cnt_bits(max_u(PWRUP_CYC, CONV_CYC));

    cnv_evt_t         evt;
    logic             cnv_lvl;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_zero;
    seq_e             state;
    logic             done;

    adcseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cnv_start),
        .evt      (evt)
    );

    assign cnv_lvl = evt.level;

    adcseq_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_zero)
    );

    adcseq_fsm #(
        .PWRUP_CYC (PWRUP_CYC),
        .CONV_CYC  (CONV_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .cfg_we     (cfg_we),
        .cfg_pwr_on (cfg_pwr_on),
        .t_zero     (t_zero),
        .t_load     (t_load),
        .t_val      (t_val),
        .state      (state),
        .done       (done)
    );

    adcseq_loader #(.DATA_W(DATA_W)) u_loader (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .rd_active   (rd_active),
        .sample_in   (sample_in),
        .load_strobe (load_strobe),
        .load_data   (load_data)
    );

    assign busy      = (state == SQ_CONV);
    assign pwr_state = pwr_of(state);

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int unsigned CONV_CYC = 115,
    parameter int unsigned DATA_W   = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              cnv_lvl,
    input logic              busy,
    input logic              rd_active,
    input logic              load_strobe,
    input logic [1:0]        pwr_state,
    input logic [DATA_W-1:0] load_data
);

    localparam int unsigned RUN_W = $clog2(CONV_CYC + 2) + 1;

    logic [RUN_W-1:0] run_q;
    logic             armed;

    always_ff @(posedge clk) begin
        armed <= 1'b1;
        if (rst || !busy) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        armed && $past(rst) |-> (pwr_state == 2'd0 && !busy && !load_strobe)); // R1

    AST_BUSY_WHEN_ON: assert property (@(posedge clk) disable iff (rst)
        busy |-> pwr_state == 2'd2); // R2

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_q == RUN_W'(CONV_CYC)); // R2

    AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && !$past(rd_active) |-> load_strobe); // R3

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_strobe |-> $stable(load_data)); // R3

    AST_MODE_STAY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && $past(cnv_lvl) |-> pwr_state == 2'd2); // R4

    AST_MODE_SLEEP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && !$past(cnv_lvl) |-> pwr_state == 2'd0); // R4

    AST_OFF_EXIT: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_state) == 2'd0 && pwr_state != 2'd0 |-> pwr_state == 2'd1); // R5

    AST_WARM_EXIT: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_state) == 2'd1 && pwr_state != 2'd1 |-> pwr_state == 2'd2); // R6

    AST_NO_LOAD_IN_READ: assert property (@(posedge clk) disable iff (rst)
        $past(rd_active) |-> !load_strobe); // R8

endmodule

bind adcseq_top adcseq_chk #(
    .CONV_CYC (CONV_CYC),
    .DATA_W   (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnv_lvl     (cnv_lvl),
    .busy        (busy),
    .rd_active   (rd_active),
    .load_strobe (load_strobe),
    .pwr_state   (pwr_state),
    .load_data   (load_data)
);

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;

    localparam int P  = 6;
    localparam int C  = 9;
    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic          cfg_pwr_on;
    logic          cnv;
    logic          rd_active;
    logic [DW-1:0] sample_in;
    logic          busy;
    logic [1:0]    pwr;
    logic          strobe;
    logic [DW-1:0] ldata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;
    bit cur_on = 0;

    always #10 clk = ~clk;

    adcseq_top #(
        .PWRUP_CYC (P),
        .CONV_CYC  (C),
        .DATA_W    (DW)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_pwr_on  (cfg_pwr_on),
        .cnv_start   (cnv),
        .rd_active   (rd_active),
        .sample_in   (sample_in),
        .busy        (busy),
        .pwr_state   (pwr),
        .load_strobe (strobe),
        .load_data   (ldata)
    );

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish earlier", cyc_cnt);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_start(input int w);
        return 3 + ((w > P) ? w : P);
    endfunction

    function automatic int exp_mode(input bit hi);
        return hi ? 2 : 0;
    endfunction

    // wake from off with a convert-start pulse of w cycles
    task automatic wake(input int w);
        bit    seen = 0;
        string req  = (w > P) ? "R7" : "R6";
        cnv = 1'b1;
        for (int t = 1; t <= w + P + 20; t++) begin
            @(negedge clk);
            if (t == w) cnv = 1'b0;
            if (t == 3) chk_eq("R5", "warming after rise", pwr, 1);
            if (w > P && t == 3 + P) begin
                chk_eq("R7", "on after warm-up", pwr, 2);
                chk_eq("R7", "idle after warm-up", busy, 0);
            end
            if (busy) begin
                chk_eq(req, "conversion start cycle", t, exp_start(w));
                seen = 1;
                break;
            end
        end
        if (!seen) chk_eq(req, "conversion started", 0, 1);
    endtask

    task automatic start_from_ready();
        bit seen = 0;
        cnv = 1'b0;
        for (int t = 1; t <= 10; t++) begin
            @(negedge clk);
            if (t == 2) chk_eq("R10", "no reaction before third edge", busy, 0);
            if (busy) begin
                chk_eq("R10", "start on third edge (R2)", t, 3);
                seen = 1;
                break;
            end
        end
        if (!seen) chk_eq("R2", "conversion started from on", 0, 1);
    endtask

    task automatic run_conv(input bit hi, input bit rd, input bit glitch, input logic [DW-1:0] val);
        int run = 1;
        sample_in = val;
        rd_active = rd;
        if (glitch) begin
            cnv = 1'b1;
            @(negedge clk);
            if (busy) run++;
            cnv = 1'b0;
            @(negedge clk);
            if (busy) run++;
        end
        if (hi) cnv = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (!busy) break;
            run++;
        end
        chk_eq(glitch ? "R9" : "R2", "busy length", run, C);
        chk_eq("R4", "power state after conversion", pwr, exp_mode(hi));
        if (!rd) begin
            chk_eq("R3", "load strobe at end", strobe, 1);
            chk_eq("R3", "loaded data", ldata, val);
        end else begin
            chk_eq("R8", "strobe held during read", strobe, 0);
            cyc(2);
            chk_eq("R8", "strobe still held", strobe, 0);
            sample_in = ~val;
            rd_active = 1'b0;
            cyc(1);
            chk_eq("R8", "strobe after read", strobe, 1);
            chk_eq("R8", "held data", ldata, val);
        end
        cyc(1);
        chk_eq("R3", "strobe lasts one cycle", strobe, 0);
        if (glitch && hi) begin
            cyc(3);
            chk_eq("R9", "no extra conversion", busy, 0);
            chk_eq("R9", "still on", pwr, 2);
        end
        cur_on = hi;
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst        = 1'b1;
        cfg_we     = 1'b0;
        cfg_pwr_on = 1'b0;
        cnv        = 1'b0;
        rd_active  = 1'b0;
        sample_in  = '0;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        chk_eq("R1", "reset power state", pwr, 0);
        chk_eq("R1", "reset busy", busy, 0);
        chk_eq("R1", "reset strobe", strobe, 0);

        // unconfigured: pulses have no effect
        cnv = 1'b1;
        cyc(4);
        cnv = 1'b0;
        cyc(6);
        chk_eq("R1", "pulse before configuration ignored", pwr, 0);

        cfg_we     = 1'b1;
        cfg_pwr_on = 1'b1;
        cyc(1);
        cfg_we = 1'b0;
        chk_eq("R1", "config write starts warm-up", pwr, 1);
        cyc(P - 1);
        chk_eq("R5", "still warming at last cycle", pwr, 1);
        cyc(1);
        chk_eq("R5", "on after PWRUP_CYC", pwr, 2);
        chk_eq("R5", "idle after config warm-up", busy, 0);

        cnv = 1'b1;
        cyc(4);
        chk_eq("R2", "rise while on does not start", busy, 0);
        start_from_ready();
        run_conv(1, 0, 0, 10'h2A5);
        start_from_ready();
        run_conv(0, 0, 0, 10'h15A);

        wake(1);
        run_conv(0, 0, 0, 10'h3FF);
        wake(P);
        run_conv(1, 0, 1, 10'h001);
        start_from_ready();
        run_conv(0, 1, 0, 10'h1C3);
        wake(P + 4);
        run_conv(0, 0, 1, 10'h000);

        for (int i = 0; i < 40; i++) begin
            bit hi;
            if (cur_on) start_from_ready();
            else wake(1 + int'($urandom % (P + 4)));
            hi = 1'($urandom % 2);
            run_conv(hi, ($urandom % 4) == 0, ($urandom % 3) == 0, DW'($urandom % 1024));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule